// File: doc/BRIEF.md
# Set/Clear Interrupt Status Controller

This block holds a 32-bit interrupt status word and turns changes to it into an interrupt towards the host. Bits are set in two ways. Software can write a set register, and internal engines can pulse an event input. The compute engine sets bit 0 and the DMA engine sets bit 8. Software clears bits by writing a separate clear register, where each 1 in the data clears one bit. The status word is read back at its own read-only offset.

The block signals the host in one of two ways, chosen by the `msg_mode` input. In level mode a sticky line is raised when a set leaves the status nonzero. The line drops only when a clear empties the status. In message mode every set that leaves the status nonzero produces a one-cycle request pulse. A clear sends nothing in message mode, and message mode never moves the level line. When a clear and a set land in the same cycle, the clear is applied first, so the new bits survive.

Top module: `irq_set_clear`

## Requirements
- R1: While reset is asserted, and right after it, the status is 0x00000000, `irq_level` is 0 and `msg_req` is 0.
- R2: A read address of 0x24 returns the current status on `reg_rdata`, and any other address returns zero. A write to 0x24 does not change the status.
- R3: A write to offset 0x60 ORs `reg_wdata` into the status. The new value is visible one cycle later.
- R4: A write to offset 0x64 clears every status bit that is 1 in `reg_wdata` and leaves the other bits as they were.
- R5: `evt_in[0]` (compute done) sets status bit 0 and `evt_in[1]` (DMA done) sets status bit 8, in the same way as a software set.
- R6: In level mode (`msg_mode`=0), a set that leaves the status nonzero drives `irq_level` high in the next cycle.
- R7: In level mode, `irq_level` goes low only after a clear write that leaves the status zero. A partial clear keeps it high.
- R8: In message mode (`msg_mode`=1), each set that leaves the status nonzero gives exactly one cycle of `msg_req` in the next cycle. `irq_level` keeps its value.
- R9: In message mode, a clear write produces no `msg_req` and leaves `irq_level` unchanged, even when the status becomes zero.
- R10: When a clear write and an event arrive in the same cycle, the clear is applied first and the event bits are then set.
- R11: `msg_req` is never asserted in level mode. A set that leaves the status zero raises nothing in either mode.
- R12: A write to any offset other than 0x60 and 0x64 leaves the status and both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_in | input | 2 | Event pulses: bit 0 compute done, bit 1 DMA done |
| msg_mode | input | 1 | 1 selects message requests, 0 selects the level line |
| irq_level | output | 1 | Level interrupt line |
| msg_req | output | 1 | One-cycle message request |

## Verification
The bench targets the asymmetry between the two modes. A design that dropped the level line in message mode, or pulsed on a clear, would show a wrong `irq_level` or a stray `msg_req` right after a full clear. Partial clears in level mode catch a line that falls on any clear, not only a clear that leaves the status at zero. A clear of bit 8 in the same cycle as a DMA event catches a design that applies the set before the clear and loses the event. A set of zero data, and writes to the read-only and unused offsets, catch pulses sent on empty status and writes decoded too loosely.

// File: rtl/irq_set_clear.sv
module irq_set_clear #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE  = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_LOWER  = 8'h64,
  parameter logic [31:0] CALC_CODE = 32'h0000_0001,
  parameter logic [31:0] DMA_CODE  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        evt_in,
  input  logic              msg_mode,
  output logic              irq_level,
  output logic              msg_req
);

  logic [31:0] status_q, set_vec, clr_vec, status_d;
  logic        wr_raise, wr_lower, raise, nonzero;

  assign wr_raise = reg_wr && (reg_addr == OFS_RAISE);
  assign wr_lower = reg_wr && (reg_addr == OFS_LOWER);

  assign set_vec = (wr_raise  ? reg_wdata : 32'h0)
                 | (evt_in[0] ? CALC_CODE : 32'h0)
                 | (evt_in[1] ? DMA_CODE  : 32'h0);
  assign clr_vec = wr_lower ? reg_wdata : 32'h0;
  assign raise   = wr_raise || (|evt_in);

  assign status_d = (status_q & ~clr_vec) | set_vec;
  assign nonzero  = |status_d;

  assign reg_rdata = (reg_addr == OFS_STATUS) ? status_q : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= 32'h0;
      irq_level <= 1'b0;
      msg_req   <= 1'b0;
    end else begin
      status_q <= status_d;
      msg_req  <= msg_mode && raise && nonzero;
      if (!msg_mode) begin
        if (raise && nonzero)
          irq_level <= 1'b1;
        else if (wr_lower && !nonzero)
          irq_level <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_set_clear_chk.sv
module irq_set_clear_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_RAISE = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_LOWER = 8'h64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        evt_in,
  input logic              msg_mode,
  input logic              irq_level,
  input logic              msg_req,
  input logic [31:0]       status_q
);

  // R3
  raise_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_RAISE |=> (status_q & $past(reg_wdata)) == $past(reg_wdata));

  // R4
  lower_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_LOWER && evt_in == 2'b00 |=> (status_q & $past(reg_wdata)) == 32'h0);

  // R6
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_level) |-> status_q != 32'h0 && !$past(msg_mode));

  // R7
  lvl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |-> status_q == 32'h0);

  // R9
  msg_lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_mode) |-> $stable(irq_level));

  // R11
  msg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(msg_mode) && status_q != 32'h0);

endmodule

bind irq_set_clear irq_set_clear_chk #(
  .ADDR_W(ADDR_W), .OFS_RAISE(OFS_RAISE), .OFS_LOWER(OFS_LOWER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_in(evt_in), .msg_mode(msg_mode),
  .irq_level(irq_level), .msg_req(msg_req), .status_q(status_q)
);

// File: tb/test_irq_set_clear.sv
`timescale 1ns/1ps
module test_irq_set_clear;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h24;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [1:0]  evt_in = 2'b00;
  logic        msg_mode = 1'b0;
  logic        irq_level, msg_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_set_clear i_irq_set_clear (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .msg_mode(msg_mode), .irq_level(irq_level), .msg_req(msg_req)
  );

  // {wr, addr, wdata, evt, mode, exp_status, exp_level, exp_msg}
  localparam int NV = 18;
  localparam logic [77:0] VEC [0:NV-1] = '{
    {1'b1, 8'h60, 32'h0000_00F0, 2'b00, 1'b0, 32'h0000_00F0, 1'b1, 1'b0}, // R3 R6
    {1'b1, 8'h64, 32'h0000_0030, 2'b00, 1'b0, 32'h0000_00C0, 1'b1, 1'b0}, // R4 R7 partial
    {1'b1, 8'h64, 32'h0000_00C0, 2'b00, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7 empty
    {1'b0, 8'h00, 32'h0000_0000, 2'b01, 1'b0, 32'h0000_0001, 1'b1, 1'b0}, // R5 compute
    {1'b0, 8'h00, 32'h0000_0000, 2'b10, 1'b0, 32'h0000_0101, 1'b1, 1'b0}, // R5 DMA
    {1'b1, 8'h24, 32'hFFFF_FFFF, 2'b00, 1'b0, 32'h0000_0101, 1'b1, 1'b0}, // R2 read-only
    {1'b1, 8'h40, 32'hFFFF_FFFF, 2'b00, 1'b0, 32'h0000_0101, 1'b1, 1'b0}, // R12
    {1'b1, 8'h64, 32'h0000_0101, 2'b01, 1'b0, 32'h0000_0001, 1'b1, 1'b0}, // R10
    {1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7
    {1'b1, 8'h60, 32'h8000_0000, 2'b00, 1'b1, 32'h8000_0000, 1'b0, 1'b1}, // R8
    {1'b0, 8'h00, 32'h0000_0000, 2'b01, 1'b1, 32'h8000_0001, 1'b0, 1'b1}, // R8 repeat
    {1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R9
    {1'b1, 8'h60, 32'h0000_0000, 2'b00, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R11 empty set
    {1'b1, 8'h60, 32'h0000_0005, 2'b00, 1'b0, 32'h0000_0005, 1'b1, 1'b0}, // R11 R6
    {1'b1, 8'h64, 32'h0000_0005, 2'b00, 1'b1, 32'h0000_0000, 1'b1, 1'b0}, // R9 holds line
    {1'b1, 8'h64, 32'h0000_0000, 2'b00, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7
    {1'b1, 8'h64, 32'hFFFF_FFFF, 2'b10, 1'b1, 32'h0000_0100, 1'b0, 1'b1}, // R10 R8
    {1'b0, 8'h00, 32'h0000_0000, 2'b00, 1'b1, 32'h0000_0100, 1'b0, 1'b0}  // R8 one cycle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_back(output logic [31:0] v);
    reg_addr = 8'h24;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic step(input logic [77:0] v, input int idx);
    logic [31:0] st;
    @(negedge clk);
    reg_wr    = v[77];
    reg_addr  = v[76:69];
    reg_wdata = v[68:37];
    evt_in    = v[36:35];
    msg_mode  = v[34];
    @(posedge clk);
    #0.5;
    reg_wr = 1'b0;
    evt_in = 2'b00;
    read_back(st);
    chk($sformatf("row %0d status R2/R3/R4/R5/R10/R12", idx), st, v[33:2]);
    chk($sformatf("row %0d irq_level R6/R7/R9", idx), {31'h0, irq_level}, {31'h0, v[1]});
    chk($sformatf("row %0d msg_req R8/R9/R11", idx), {31'h0, msg_req}, {31'h0, v[0]});
  endtask

  initial begin
    logic [31:0] st;
    #1;
    read_back(st);
    // R1 during reset
    chk("R1 status in reset", st, 32'h0);
    chk("R1 level in reset", {31'h0, irq_level}, 32'h0);
    chk("R1 msg in reset", {31'h0, msg_req}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(VEC[i], i);

    // R2 other address reads zero while status is nonzero
    reg_addr = 8'h60;
    #0.5;
    chk("R2 non-status read", reg_rdata, 32'h0);

    // R1 reset mid-run with level high and status nonzero
    step({1'b1, 8'h60, 32'h0000_0A00, 2'b00, 1'b0, 32'h0000_0B00, 1'b1, 1'b0}, 100);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    read_back(st);
    chk("R1 status after reset", st, 32'h0);
    chk("R1 level after reset", {31'h0, irq_level}, 32'h0);
    chk("R1 msg after reset", {31'h0, msg_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 back-to-back sets give one pulse each
    step({1'b0, 8'h00, 32'h0, 2'b01, 1'b1, 32'h0000_0001, 1'b0, 1'b1}, 101);
    step({1'b0, 8'h00, 32'h0, 2'b10, 1'b1, 32'h0000_0101, 1'b0, 1'b1}, 102);
    step({1'b0, 8'h00, 32'h0, 2'b00, 1'b1, 32'h0000_0101, 1'b0, 1'b0}, 103);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule